// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a memory-mapped general-purpose I/O port of up to 32 lines, reached over a simple synchronous register bus. The bus has an address, a write enable, 32-bit write data and combinational 32-bit read data. Software never has to read, modify and write back a register. Output data and line direction each have one address that sets bits and another that clears them. A 1 in the written word acts on its own line only. A 0 leaves its line as it was.

The port drives one output-enable and one output-data signal per line toward the pad cells. A status address reads back the direction register. The external pin levels pass through a two-stage synchronizer and can be read at the pin-level address. Pad cells, interrupt generation and input filtering live outside this block.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is asserted and right after it, every output-data bit and every direction bit is 0, so `pad_out` and `pad_oe` are all zero and every line is an input.
- R2: A write to byte address 0x000 sets the output-data bit of every line whose write-data bit is 1 and leaves the other lines unchanged. The new value appears on `pad_out` after the clock edge of the write.
- R3: A write to byte address 0x004 clears the output-data bit of every line whose write-data bit is 1 and leaves the other lines unchanged.
- R4: Writes to 0x010 and 0x014 set and clear direction bits in the same per-line way. `pad_oe` shows the direction register, and a 1 makes the line an output.
- R5: A read of 0x018 returns the current direction register in bits [N-1:0].
- R6: A read of 0x080 returns the pin levels in bits [N-1:0], delayed by a two-flop synchronizer. A pin change made before clock edge k is visible after edge k+1 and not after edge k.
- R7: Reads of 0x000, 0x004, 0x010, 0x014 and of any unmapped address return 0.
- R8: Writes to the read-only addresses 0x018 and 0x080 or to unmapped addresses, and bus cycles with the write enable low, change neither `pad_out` nor `pad_oe`.
- R9: Bits at or above the configured line count N always read as 0 and cannot be set by any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | N_LINES | Asynchronous pin levels from the pads |
| pad_oe | output | N_LINES | Per-line output enable (direction register) |
| pad_out | output | N_LINES | Per-line output data |

## Verification
On every cycle the assertions check the following:
- each set or clear strobe is an OR or AND-NOT of the previous register value with the write data;
- both output registers hold steady when no write targets them;
- the status and set/clear addresses read back as required;
- bits above the line count stay zero;
- the pin-level read equals the pin value from two edges earlier.

Only the bench scenarios show that every value of an 8-line port is reached through sweeps of set and clear patterns. They also show that a pin change is still hidden one edge after it occurs. Finally, they show that writes to read-only and unmapped addresses leave the pads untouched, as observed on the pad outputs.

// File: rtl/gpio_sc_pkg.sv
`timescale 1ns/1ps
package gpio_sc_pkg;
  localparam logic [31:0] OFF_DATA_SET = 32'h000;
  localparam logic [31:0] OFF_DATA_CLR = 32'h004;
  localparam logic [31:0] OFF_DIR_SET  = 32'h010;
  localparam logic [31:0] OFF_DIR_CLR  = 32'h014;
  localparam logic [31:0] OFF_DIR_STAT = 32'h018;
  localparam logic [31:0] OFF_PIN_LVL  = 32'h080;

  // Mask of the implemented lines inside a 32-bit word.
  function automatic logic [31:0] line_mask(input int unsigned n);
    line_mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // Next value of a set/clear register: set bits first, then cleared bits.
  function automatic logic [31:0] next_setclr(input logic [31:0] cur,
                                              input logic        do_set,
                                              input logic        do_clr,
                                              input logic [31:0] bits);
    logic [31:0] v;
    v = cur;
    if (do_set) v = v | bits;
    if (do_clr) v = v & ~bits;
    next_setclr = v;
  endfunction
endpackage

// File: rtl/gpio_sc_bitreg.sv
`timescale 1ns/1ps
module gpio_sc_bitreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  import gpio_sc_pkg::*;

  logic [31:0] nxt_w;

  always_comb nxt_w = next_setclr(32'(q), set_stb, clr_stb, 32'(bits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_w[W-1:0];
  end
endmodule

// File: rtl/gpio_sc_sync.sv
`timescale 1ns/1ps
module gpio_sc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_rdmux.sv
`timescale 1ns/1ps
module gpio_sc_rdmux #(
  parameter int unsigned W = 32
) (
  input  logic [31:0]  addr32,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_lvl,
  output logic [31:0]  rdata
);
  import gpio_sc_pkg::*;

  always_comb begin
    rdata = '0;
    if (addr32 == OFF_DIR_STAT)     rdata = 32'(dir_q);
    else if (addr32 == OFF_PIN_LVL) rdata = 32'(pin_lvl);
  end
endmodule

// File: rtl/gpio_setclr_port.sv
`timescale 1ns/1ps
module gpio_setclr_port #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pad_oe,
  output logic [N_LINES-1:0] pad_out
);
  import gpio_sc_pkg::*;

  localparam int unsigned NREG = 2;  // 0: output data, 1: direction

  logic [31:0]        addr32;
  logic               wr_dset, wr_dclr, wr_oset, wr_oclr;
  logic [NREG-1:0]    set_stb, clr_stb;
  logic [N_LINES-1:0] reg_q [NREG];
  logic [N_LINES-1:0] pin_lvl;

  assign addr32  = 32'(bus_addr);
  assign wr_dset = bus_we && (addr32 == OFF_DATA_SET);
  assign wr_dclr = bus_we && (addr32 == OFF_DATA_CLR);
  assign wr_oset = bus_we && (addr32 == OFF_DIR_SET);
  assign wr_oclr = bus_we && (addr32 == OFF_DIR_CLR);
  assign set_stb = {wr_oset, wr_dset};
  assign clr_stb = {wr_oclr, wr_dclr};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    gpio_sc_bitreg #(.W(N_LINES)) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb[g]),
      .clr_stb (clr_stb[g]),
      .bits    (bus_wdata[N_LINES-1:0]),
      .q       (reg_q[g])
    );
  end

  assign pad_out = reg_q[0];
  assign pad_oe  = reg_q[1];

  gpio_sc_sync #(.W(N_LINES), .STAGES(2)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_lvl)
  );

  gpio_sc_rdmux #(.W(N_LINES)) rdmux_i (
    .addr32  (addr32),
    .dir_q   (reg_q[1]),
    .pin_lvl (pin_lvl),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/gpio_sc_checker.sv
`timescale 1ns/1ps
module gpio_sc_checker #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [N_LINES-1:0] pin_in,
  input logic [N_LINES-1:0] pad_oe,
  input logic [N_LINES-1:0] pad_out,
  input logic               wr_dset,
  input logic               wr_dclr,
  input logic               wr_oset,
  input logic               wr_oclr
);
  import gpio_sc_pkg::*;

  localparam logic [31:0] LMASK = line_mask(N_LINES);

  logic [31:0]        a32;
  logic [N_LINES-1:0] wbits;
  logic               data_hit, dir_hit, setclr_rd;
  logic [1:0]         since_rst;

  assign a32       = 32'(bus_addr);
  assign wbits     = bus_wdata[N_LINES-1:0];
  assign data_hit  = bus_we && (a32 == OFF_DATA_SET || a32 == OFF_DATA_CLR);
  assign dir_hit   = bus_we && (a32 == OFF_DIR_SET  || a32 == OFF_DIR_CLR);
  assign setclr_rd = (a32 == OFF_DATA_SET) || (a32 == OFF_DATA_CLR) ||
                     (a32 == OFF_DIR_SET)  || (a32 == OFF_DIR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  p_data_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dset |=> pad_out == ($past(pad_out) | $past(wbits)));
  p_data_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dclr |=> pad_out == ($past(pad_out) & ~$past(wbits)));
  p_dir_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oset |=> pad_oe == ($past(pad_oe) | $past(wbits)));
  p_dir_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oclr |=> pad_oe == ($past(pad_oe) & ~$past(wbits)));
  p_dir_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a32 == OFF_DIR_STAT) |-> bus_rdata == 32'(pad_oe));
  p_pin_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2 && a32 == OFF_PIN_LVL) |-> bus_rdata == 32'($past(pin_in, 2)));
  p_setclr_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_rd |-> bus_rdata == 32'd0);
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_hit |=> $stable(pad_out));
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_hit |=> $stable(pad_oe));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LMASK) == 32'd0);
endmodule

bind gpio_setclr_port gpio_sc_checker #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .wr_dset   (wr_dset),
  .wr_dclr   (wr_dclr),
  .wr_oset   (wr_oset),
  .wr_oclr   (wr_oclr)
);

// File: tb/gpio_setclr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_setclr_port_tb_top;
  localparam int N  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = 8'h40;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pad_oe, pad_out;

  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_setclr_port #(.N_LINES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One write cycle; returns at the falling edge after the capturing edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h40; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  logic [31:0] exp_d = '0;
  logic [31:0] exp_o = '0;

  initial begin
    logic [31:0] v;
    logic [31:0] prev_pin;
    repeat (3) @(negedge clk);
    chk("R1 pad_out in reset", 32'(pad_out), 32'h0);
    chk("R1 pad_oe in reset", 32'(pad_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h18, v);
    chk("R1 direction after reset", v, 32'h0);
    chk("R1 pad_out after reset", 32'(pad_out), 32'h0);

    // R2/R3/R4/R5: sweeps of set and clear patterns over all 8-bit values
    for (int k = 0; k < 256; k++) begin
      logic [31:0] c;
      wr(8'h00, 32'(k));
      exp_d = exp_d | 32'(k);
      chk("R2 data set", 32'(pad_out), exp_d);
      c = 32'((k * 37 + 11) & 255);
      wr(8'h04, c);
      exp_d = exp_d & ~c;
      chk("R3 data clear", 32'(pad_out), exp_d);
      wr(8'h10, 32'(k));
      exp_o = exp_o | 32'(k);
      chk("R4 dir set", 32'(pad_oe), exp_o);
      rd(8'h18, v);
      chk("R5 dir status", v, exp_o);
      c = 32'((k * 91 + 5) & 255);
      wr(8'h14, c);
      exp_o = exp_o & ~c;
      chk("R4 dir clear", 32'(pad_oe), exp_o);
    end

    // R7: zero reads with non-zero state
    wr(8'h00, 32'hA5); exp_d = exp_d | 32'hA5;
    wr(8'h10, 32'h5A); exp_o = exp_o | 32'h5A;
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    foreach (v[i]) begin end
    rd(8'h00, v); chk("R7 read data-set addr", v, 0);
    rd(8'h04, v); chk("R7 read data-clear addr", v, 0);
    rd(8'h10, v); chk("R7 read dir-set addr", v, 0);
    rd(8'h14, v); chk("R7 read dir-clear addr", v, 0);
    rd(8'h40, v); chk("R7 read unmapped 0x40", v, 0);
    rd(8'h7C, v); chk("R7 read unmapped 0x7C", v, 0);
    rd(8'h84, v); chk("R7 read unmapped 0x84", v, 0);

    // R8: writes that must not touch the pads
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R8 write dir-status data", 32'(pad_out), exp_d);
    chk("R8 write dir-status dir", 32'(pad_oe), exp_o);
    wr(8'h80, 32'hFFFF_FFFF);
    chk("R8 write pin-level data", 32'(pad_out), exp_d);
    chk("R8 write pin-level dir", 32'(pad_oe), exp_o);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R8 write unmapped data", 32'(pad_out), exp_d);
    chk("R8 write unmapped dir", 32'(pad_oe), exp_o);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
    @(negedge clk);
    chk("R8 we low data", 32'(pad_out), exp_d);
    bus_addr = 8'h14;
    @(negedge clk);
    chk("R8 we low dir", 32'(pad_oe), exp_o);
    bus_addr = 8'h40; bus_wdata = '0;

    // R6: synchronizer latency for every pin pattern
    rd(8'h80, prev_pin);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      pin_in = p[N-1:0];
      @(negedge clk);
      rd(8'h80, v);
      chk("R6 hidden after one edge", v, prev_pin);
      @(negedge clk);
      rd(8'h80, v);
      chk("R6 visible after two edges", v, 32'(p));
      prev_pin = 32'(p);
    end

    // R9: bits above the line count
    wr(8'h10, 32'hFFFF_FFFF);
    exp_o = 32'hFF;
    rd(8'h18, v);
    chk("R9 dir status upper bits", v, exp_o);
    wr(8'h04, 32'hFFFF_FFFF); exp_d = '0;
    wr(8'h00, 32'hFFFF_FF00);
    chk("R9 upper data bits not set", 32'(pad_out), 32'h0);
    rd(8'h80, v);
    chk("R9 pin level upper bits", v, 32'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule